// File: doc/BRIEF.md
# Flash Bus Mode Decoder

This block is the control front end of a parallel NOR-style flash device. It samples the device reset pin, a group of chip-enable lines, output-enable, write-enable, the byte-width pin and a two-bit program-voltage level on the core clock. It then decides which bus mode the device is in: power-down, standby, output disable, read, write or an illegal read/write conflict. From that mode it produces the per-bit output enables and the data for the tri-state data bus, and it drives the open-drain busy/ready pin.

Read data comes from a stub array input. A stub status-select input from the command interpreter chooses between array data and the status byte. While the internal write state machine is actively running an algorithm, a status read drives only the ready bit and leaves every other bit floating.

A write cycle is closed when write-enable or chip-enable rises. At that point the address and data held during the write are handed to the command interpreter as a one-cycle strobe, but only when the program voltage is at the high level. A write attempted at any other voltage level is refused. It also sets a sticky voltage-error flag, which the status byte reports until the device reset pin is asserted.

Top module: `flash_bus_front`

## Requirements
- R1: While the sampled device reset pin is low, `bus_mode` is 0 (power-down), `dq_oe` is all zero, `sts_pull_low` is 0, and the voltage-error flag is cleared one clock later.
- R2: When the reset pin is high and any chip-enable line is high, `bus_mode` is 1 (standby) and `dq_oe` is all zero.
- R3: With all chip-enable lines low, output-enable high and write-enable high, `bus_mode` is 2 (output disable) and `dq_oe` is all zero.
- R4: An array read (mode 3, status select low) drives `array_data` with `dq_oe` = 16'hFFFF in 16-bit mode (byte pin high) and with `dq_oe` = 16'h00FF, lower byte only, in 8-bit mode (byte pin low).
- R5: A status read while the state machine is not actively running drives a status byte on bits 7:0 with bit 7 = 1 (ready), bit 6 = erase suspended, bit 3 = voltage error, bit 2 = program suspended and all other bits 0. In 16-bit mode bits 15:8 are driven as 0.
- R6: A status read while `wsm_busy` is high and `prog_susp` is low drives only bit 7 (`dq_oe` = 16'h0080), with value 0, in either width.
- R7: `sts_pull_low` is 1 exactly when the sampled reset pin is high, `wsm_busy` is 1 and `prog_susp` is 0. Erase suspend with no program running (busy low) releases it.
- R8: Output-enable and write-enable both low with the chip enabled gives `bus_mode` 5, `bus_conflict` 1 and `dq_oe` all zero. A conflict cycle never produces a command strobe.
- R9: When a write cycle (mode 4) is followed by standby or output disable, and the voltage level is 2'b10, `cmd_strobe` is high for exactly one clock, two clocks after the closing pin edge. It carries the address and data held during the write, and in 8-bit mode the data's upper byte is zero.
- R10: A write closed while the voltage level is 2'b00 (lockout) or 2'b01/2'b11 (invalid) produces no strobe and sets `vpp_err`, which stays set until the reset pin is asserted.
- R11: Pins pass through one sampling register, so `bus_mode` and the bus outputs reflect pin values present before the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low logic reset |
| pin_rst_n | input | 1 | Device reset/power-down pin, active low |
| pin_ce_n | input | CE_W | Chip-enable lines, all low to select |
| pin_oe_n | input | 1 | Output enable, active low |
| pin_we_n | input | 1 | Write enable, active low |
| pin_byte_n | input | 1 | Bus width: low 8-bit, high 16-bit |
| vpp_lvl | input | 2 | Program voltage: 00 lockout, 10 high, else invalid |
| pin_addr | input | ADDR_W | Address pins |
| pin_din | input | DATA_W | Data bus input side |
| rd_status | input | 1 | Stub: read mode is status rather than array |
| array_data | input | DATA_W | Stub: array word at the current address |
| wsm_busy | input | 1 | Stub: algorithm running |
| erase_susp | input | 1 | Stub: erase suspended |
| prog_susp | input | 1 | Stub: program suspended |
| dq_out | output | DATA_W | Data bus output values |
| dq_oe | output | DATA_W | Per-bit output enable, grouped by byte lane |
| sts_pull_low | output | 1 | Open-drain busy pin pull-down |
| bus_mode | output | 3 | Decoded bus mode |
| bus_conflict | output | 1 | Output and write enable asserted together |
| cmd_strobe | output | 1 | One-cycle accepted command write |
| cmd_addr | output | ADDR_W | Address of the accepted write |
| cmd_data | output | DATA_W | Data of the accepted write |
| vpp_err | output | 1 | Sticky refused-write flag |

## Verification
The assertions watch, every cycle, that power-down, standby and conflict modes never enable a data bit, that a busy status read enables only bit 7, that the command strobe never lasts two cycles, and that the voltage-error flag cannot drop except through power-down. Only the scenarios can show the values on the bus: array and status contents in both widths, the exact cycle and captured contents of a strobe after a write-enable or chip-enable close, the refusal at lockout and invalid voltage, and the one-clock sampling latency.

// File: rtl/fbf_pkg.sv
// Shared types for the flash bus front end: bus modes, voltage codes,
// status bit positions and the sampled control-pin bundle.
package fbf_pkg;

    typedef enum logic [2:0] {
        MODE_PWRDN    = 3'd0,
        MODE_STANDBY  = 3'd1,
        MODE_OUTDIS   = 3'd2,
        MODE_READ     = 3'd3,
        MODE_WRITE    = 3'd4,
        MODE_CONFLICT = 3'd5
    } bus_mode_e;

    localparam logic [1:0] VPP_LOCK = 2'b00;
    localparam logic [1:0] VPP_HIGH = 2'b10;

    localparam int ST_READY = 7;
    localparam int ST_ESUSP = 6;
    localparam int ST_VERR  = 3;
    localparam int ST_PSUSP = 2;

    typedef struct packed {
        logic rst_pin_n;
        logic ce_ok;
        logic oe_n;
        logic we_n;
        logic byte_n;
    } ctl_pins_t;

endpackage

// File: rtl/fbf_pin_sampler.sv
// Samples the asynchronous device pins into the core clock domain with one
// register stage. Assumes pins are stable around the sampling edge (the
// surrounding system guarantees pin timing much slower than the clock).
module fbf_pin_sampler
    import fbf_pkg::*;
#(
    parameter int CE_W   = 3,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_rst_n,
    input  logic [CE_W-1:0]   pin_ce_n,
    input  logic              pin_oe_n,
    input  logic              pin_we_n,
    input  logic              pin_byte_n,
    input  logic [1:0]        vpp_lvl,
    input  logic [ADDR_W-1:0] pin_addr,
    input  logic [DATA_W-1:0] pin_din,
    output ctl_pins_t         s_ctl,
    output logic [1:0]        s_vpp,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_din
);

    logic [CE_W-1:0] s_ce_n;
    logic            s_rst_pin_n;
    logic            s_oe_n;
    logic            s_we_n;
    logic            s_byte_n;

    // Register every pin once; reset parks the device in power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_rst_pin_n <= 1'b0;
            s_ce_n      <= '1;
            s_oe_n      <= 1'b1;
            s_we_n      <= 1'b1;
            s_byte_n    <= 1'b1;
            s_vpp       <= VPP_LOCK;
            s_addr      <= '0;
            s_din       <= '0;
        end else begin
            s_rst_pin_n <= pin_rst_n;
            s_ce_n      <= pin_ce_n;
            s_oe_n      <= pin_oe_n;
            s_we_n      <= pin_we_n;
            s_byte_n    <= pin_byte_n;
            s_vpp       <= vpp_lvl;
            s_addr      <= pin_addr;
            s_din       <= pin_din;
        end
    end

    // Bundle the sampled controls; chip is selected only with every line low.
    always_comb begin
        s_ctl.rst_pin_n = s_rst_pin_n;
        s_ctl.ce_ok     = ~|s_ce_n;
        s_ctl.oe_n      = s_oe_n;
        s_ctl.we_n      = s_we_n;
        s_ctl.byte_n    = s_byte_n;
    end

endmodule

// File: rtl/fbf_mode_decode.sv
// Priority decode of the sampled control pins into one bus mode.
// Reset pin dominates, then chip select, then the illegal OE/WE overlap.
module fbf_mode_decode
    import fbf_pkg::*;
(
    input  ctl_pins_t ctl,
    output bus_mode_e mode
);

    // Pick the mode by fixed priority.
    always_comb begin
        if (!ctl.rst_pin_n)                 mode = MODE_PWRDN;
        else if (!ctl.ce_ok)                mode = MODE_STANDBY;
        else if (!ctl.oe_n && !ctl.we_n)    mode = MODE_CONFLICT;
        else if (!ctl.we_n)                 mode = MODE_WRITE;
        else if (!ctl.oe_n)                 mode = MODE_READ;
        else                                mode = MODE_OUTDIS;
    end

endmodule

// File: rtl/fbf_write_capture.sv
// Detects the close of a write cycle (write mode followed by standby or
// output disable), gates it on the program voltage and emits a one-cycle
// command strobe, or sets the sticky voltage-error flag. Assumes the sampled
// data and address are held steady while write-enable is low.
module fbf_write_capture
    import fbf_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_mode_e         s_mode,
    input  logic [1:0]        s_vpp,
    input  logic              s_byte_n,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_din,
    output logic              cmd_strobe,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              vpp_err
);

    localparam int LANE_W = DATA_W / 2;

    bus_mode_e         p_mode;
    logic [1:0]        p_vpp;
    logic              p_byte_n;
    logic [ADDR_W-1:0] p_addr;
    logic [DATA_W-1:0] p_din;
    logic              wr_close;
    logic              wr_ok;
    logic [DATA_W-1:0] wr_word;

    // Hold the previous sampled cycle so a closing edge can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_mode   <= MODE_PWRDN;
            p_vpp    <= VPP_LOCK;
            p_byte_n <= 1'b1;
            p_addr   <= '0;
            p_din    <= '0;
        end else begin
            p_mode   <= s_mode;
            p_vpp    <= s_vpp;
            p_byte_n <= s_byte_n;
            p_addr   <= s_addr;
            p_din    <= s_din;
        end
    end

    // Close of a write: write-enable or chip-enable released, not an abort.
    always_comb begin
        wr_close = (p_mode == MODE_WRITE) &&
                   ((s_mode == MODE_STANDBY) || (s_mode == MODE_OUTDIS));
        wr_ok    = wr_close && (p_vpp == VPP_HIGH);
        wr_word  = p_byte_n ? p_din : {{(DATA_W-LANE_W){1'b0}}, p_din[LANE_W-1:0]};
    end

    // Issue the strobe with the captured address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_strobe <= 1'b0;
            cmd_addr   <= '0;
            cmd_data   <= '0;
        end else begin
            cmd_strobe <= wr_ok;
            if (wr_ok) begin
                cmd_addr <= p_addr;
                cmd_data <= wr_word;
            end
        end
    end

    // Sticky refusal flag, cleared only by power-down.
    always_ff @(posedge clk) begin
        if (!rst_n)                        vpp_err <= 1'b0;
        else if (s_mode == MODE_PWRDN)     vpp_err <= 1'b0;
        else if (wr_close && !wr_ok)       vpp_err <= 1'b1;
    end

endmodule

// File: rtl/fbf_data_drive.sv
// Builds the data bus values and per-bit output enables from the bus mode,
// the width pin and the read source. Lane 0 carries bits 7:0; the upper
// lanes are used only in 16-bit mode. Assumes DATA_W is two lanes of LANE_W.
module fbf_data_drive
    import fbf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  bus_mode_e         mode,
    input  logic              byte_n,
    input  logic              rd_status,
    input  logic [DATA_W-1:0] array_data,
    input  logic              wsm_active,
    input  logic              erase_susp,
    input  logic              prog_susp,
    input  logic              vpp_err,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe
);

    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    logic [LANE_W-1:0] status_byte;
    logic              reading;

    // Assemble the idle status byte.
    always_comb begin
        status_byte           = '0;
        status_byte[ST_READY] = 1'b1;
        status_byte[ST_ESUSP] = erase_susp;
        status_byte[ST_VERR]  = vpp_err;
        status_byte[ST_PSUSP] = prog_susp;
        reading               = (mode == MODE_READ);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam bit IS_LOW = (l == 0);
        logic lane_on;

        // Drive one byte lane according to width and read source.
        always_comb begin
            lane_on = reading && (IS_LOW || byte_n);
            dq_out[l*LANE_W +: LANE_W] = '0;
            dq_oe [l*LANE_W +: LANE_W] = '0;
            if (lane_on) begin
                if (!rd_status) begin
                    dq_out[l*LANE_W +: LANE_W] = array_data[l*LANE_W +: LANE_W];
                    dq_oe [l*LANE_W +: LANE_W] = '1;
                end else if (wsm_active) begin
                    if (IS_LOW) dq_oe[l*LANE_W + ST_READY] = 1'b1;
                end else begin
                    if (IS_LOW) dq_out[l*LANE_W +: LANE_W] = status_byte;
                    dq_oe[l*LANE_W +: LANE_W] = '1;
                end
            end
        end
    end

endmodule

// File: rtl/flash_bus_front.sv
// Top of the flash bus front end: samples pins, decodes the bus mode, drives
// the data bus and the busy pin, and hands accepted writes to the command
// interpreter. Assumes the state-machine flags are already in the core clock
// domain.
module flash_bus_front
    import fbf_pkg::*;
#(
    parameter int CE_W   = 3,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_rst_n,
    input  logic [CE_W-1:0]   pin_ce_n,
    input  logic              pin_oe_n,
    input  logic              pin_we_n,
    input  logic              pin_byte_n,
    input  logic [1:0]        vpp_lvl,
    input  logic [ADDR_W-1:0] pin_addr,
    input  logic [DATA_W-1:0] pin_din,
    input  logic              rd_status,
    input  logic [DATA_W-1:0] array_data,
    input  logic              wsm_busy,
    input  logic              erase_susp,
    input  logic              prog_susp,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe,
    output logic              sts_pull_low,
    output logic [2:0]        bus_mode,
    output logic              bus_conflict,
    output logic              cmd_strobe,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              vpp_err
);

    ctl_pins_t         s_ctl;
    logic [1:0]        s_vpp;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_din;
    bus_mode_e         s_mode;
    logic              wsm_active;

    fbf_pin_sampler #(.CE_W(CE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_samp (
        .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .pin_ce_n(pin_ce_n),
        .pin_oe_n(pin_oe_n), .pin_we_n(pin_we_n), .pin_byte_n(pin_byte_n),
        .vpp_lvl(vpp_lvl), .pin_addr(pin_addr), .pin_din(pin_din),
        .s_ctl(s_ctl), .s_vpp(s_vpp), .s_addr(s_addr), .s_din(s_din)
    );

    fbf_mode_decode u_dec (
        .ctl(s_ctl), .mode(s_mode)
    );

    fbf_write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wcap (
        .clk(clk), .rst_n(rst_n), .s_mode(s_mode), .s_vpp(s_vpp),
        .s_byte_n(s_ctl.byte_n), .s_addr(s_addr), .s_din(s_din),
        .cmd_strobe(cmd_strobe), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .vpp_err(vpp_err)
    );

    // An algorithm counts as running unless program is suspended.
    always_comb begin
        wsm_active   = wsm_busy && !prog_susp;
        sts_pull_low = s_ctl.rst_pin_n && wsm_active;
        bus_mode     = s_mode;
        bus_conflict = (s_mode == MODE_CONFLICT);
    end

    fbf_data_drive #(.DATA_W(DATA_W)) u_drive (
        .mode(s_mode), .byte_n(s_ctl.byte_n), .rd_status(rd_status),
        .array_data(array_data), .wsm_active(wsm_active),
        .erase_susp(erase_susp), .prog_susp(prog_susp), .vpp_err(vpp_err),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

endmodule

// File: rtl/flash_bus_front_chk.sv
// Cycle-by-cycle checks on the bus front end, attached by bind.
module flash_bus_front_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bus_mode,
    input logic [DATA_W-1:0] dq_oe,
    input logic              sts_pull_low,
    input logic              bus_conflict,
    input logic              cmd_strobe,
    input logic              vpp_err,
    input logic              rd_status,
    input logic              wsm_busy,
    input logic              prog_susp
);

    assert_pwrdn_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode == 3'd0) |-> (dq_oe == '0 && !sts_pull_low));

    assert_standby_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode == 3'd1) |-> (dq_oe == '0));

    assert_busy_status_bit7_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode == 3'd3 && rd_status && wsm_busy && !prog_susp)
        |-> (dq_oe == DATA_W'(16'h0080)));

    assert_conflict_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_conflict |-> (dq_oe == '0));

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);

    assert_vpp_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_err && bus_mode != 3'd0) |=> vpp_err);

endmodule

bind flash_bus_front flash_bus_front_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .dq_oe(dq_oe),
    .sts_pull_low(sts_pull_low), .bus_conflict(bus_conflict),
    .cmd_strobe(cmd_strobe), .vpp_err(vpp_err), .rd_status(rd_status),
    .wsm_busy(wsm_busy), .prog_susp(prog_susp)
);

// File: tb/flash_bus_front_tb.sv
`timescale 1ns/1ps
module flash_bus_front_tb;

    localparam int CLK_NS = 5;
    localparam int NVEC   = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_rst_n = 1'b1;
    logic [2:0]  pin_ce_n = 3'b111;
    logic        pin_oe_n = 1'b1;
    logic        pin_we_n = 1'b1;
    logic        pin_byte_n = 1'b1;
    logic [1:0]  vpp_lvl = 2'b10;
    logic [23:0] pin_addr = '0;
    logic [15:0] pin_din = '0;
    logic        rd_status = 1'b0;
    logic [15:0] array_data = 16'hA5C3;
    logic        wsm_busy = 1'b0;
    logic        erase_susp = 1'b0;
    logic        prog_susp = 1'b0;
    logic [15:0] dq_out, dq_oe, cmd_data;
    logic [23:0] cmd_addr;
    logic [2:0]  bus_mode;
    logic        sts_pull_low, bus_conflict, cmd_strobe, vpp_err;

    int checks = 0;
    int fails  = 0;

    always #(CLK_NS/2.0) clk = ~clk;

    flash_bus_front u_dut (
        .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .pin_ce_n(pin_ce_n),
        .pin_oe_n(pin_oe_n), .pin_we_n(pin_we_n), .pin_byte_n(pin_byte_n),
        .vpp_lvl(vpp_lvl), .pin_addr(pin_addr), .pin_din(pin_din),
        .rd_status(rd_status), .array_data(array_data), .wsm_busy(wsm_busy),
        .erase_susp(erase_susp), .prog_susp(prog_susp), .dq_out(dq_out),
        .dq_oe(dq_oe), .sts_pull_low(sts_pull_low), .bus_mode(bus_mode),
        .bus_conflict(bus_conflict), .cmd_strobe(cmd_strobe),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .vpp_err(vpp_err)
    );

    // rst,ce[3],oe,we,byte,rds,busy,esusp,psusp,mode[3],oe16,dq16,sts
    localparam logic [46:0] VEC [NVEC] = '{
        {1'b0,3'b000,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,3'd0,16'h0000,16'h0000,1'b0},
        {1'b1,3'b010,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,3'd1,16'h0000,16'h0000,1'b0},
        {1'b1,3'b000,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,3'd2,16'h0000,16'h0000,1'b0},
        {1'b1,3'b000,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,3'd3,16'hFFFF,16'hA5C3,1'b0},
        {1'b1,3'b000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'd3,16'h00FF,16'h00C3,1'b0},
        {1'b1,3'b000,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,3'd3,16'hFFFF,16'h00C0,1'b0},
        {1'b1,3'b000,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,3'd3,16'h0080,16'h0000,1'b1},
        {1'b1,3'b000,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,3'd3,16'hFFFF,16'h0084,1'b0},
        {1'b1,3'b000,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,3'd5,16'h0000,16'h0000,1'b0},
        {1'b1,3'b000,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,3'd4,16'h0000,16'h0000,1'b0},
        {1'b1,3'b110,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,3'd1,16'h0000,16'h0000,1'b1},
        {1'b1,3'b000,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,3'd3,16'h00FF,16'h00C0,1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_pins();
        pin_rst_n = 1'b1; pin_ce_n = 3'b000; pin_oe_n = 1'b1; pin_we_n = 1'b1;
        rd_status = 1'b0; wsm_busy = 1'b0; erase_susp = 1'b0; prog_susp = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // Reset state: sampled pins park in power-down (R1).
        repeat (3) @(negedge clk);
        chk("R1 reset mode", 32'(bus_mode), 32'd0);
        chk("R1 reset oe", 32'(dq_oe), 32'h0);
        chk("R9 reset strobe", 32'(cmd_strobe), 32'd0);
        chk("R10 reset vpp_err", 32'(vpp_err), 32'd0);
        rst_n = 1'b1;

        // Table walk: mode, enables, driven bits and busy pin (R1..R8).
        for (int i = 0; i < NVEC; i++) begin
            {pin_rst_n, pin_ce_n, pin_oe_n, pin_we_n, pin_byte_n, rd_status,
             wsm_busy, erase_susp, prog_susp} = VEC[i][46:36];
            @(negedge clk);
            chk($sformatf("R2/R3/R8 vec%0d mode", i), 32'(bus_mode), 32'(VEC[i][35:33]));
            chk($sformatf("R4/R5/R6 vec%0d oe", i), 32'(dq_oe), 32'(VEC[i][32:17]));
            chk($sformatf("R4/R5/R6 vec%0d dq", i), 32'(dq_out & VEC[i][32:17]), 32'(VEC[i][16:1]));
            chk($sformatf("R7 vec%0d sts", i), 32'(sts_pull_low), 32'(VEC[i][0]));
            chk($sformatf("R8 vec%0d conflict", i), 32'(bus_conflict), 32'(VEC[i][35:33] == 3'd5));
        end

        // Write closed by write-enable, 16-bit, high voltage (R9).
        idle_pins(); pin_byte_n = 1'b1; vpp_lvl = 2'b10;
        repeat (3) @(negedge clk);
        pin_addr = 24'h000012; pin_din = 16'hBEEF; pin_we_n = 1'b0;
        @(negedge clk);
        pin_we_n = 1'b1;
        @(negedge clk);
        chk("R9 no strobe yet", 32'(cmd_strobe), 32'd0);
        @(negedge clk);
        chk("R9 strobe", 32'(cmd_strobe), 32'd1);
        chk("R9 data", 32'(cmd_data), 32'hBEEF);
        chk("R9 addr", 32'(cmd_addr), 32'h12);
        @(negedge clk);
        chk("R9 strobe one cycle", 32'(cmd_strobe), 32'd0);

        // Write closed by chip-enable, 8-bit mode (R9).
        pin_byte_n = 1'b0; pin_addr = 24'h0000A7; pin_din = 16'h1234; pin_we_n = 1'b0;
        @(negedge clk);
        pin_ce_n = 3'b100;
        @(negedge clk);
        @(negedge clk);
        chk("R9 ce close strobe", 32'(cmd_strobe), 32'd1);
        chk("R9 byte data", 32'(cmd_data), 32'h0034);
        chk("R9 ce close addr", 32'(cmd_addr), 32'hA7);
        idle_pins(); pin_byte_n = 1'b1;
        repeat (2) @(negedge clk);

        // Write at lockout refused, flag sticky and reported (R10, R5).
        vpp_lvl = 2'b00; pin_din = 16'h5555; pin_we_n = 1'b0;
        @(negedge clk);
        pin_we_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 lockout no strobe", 32'(cmd_strobe), 32'd0);
        chk("R10 vpp_err set", 32'(vpp_err), 32'd1);
        pin_oe_n = 1'b0; rd_status = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 status verr bit", 32'(dq_out), 32'h0088);
        chk("R10 vpp_err held", 32'(vpp_err), 32'd1);
        pin_rst_n = 1'b0;
        @(negedge clk);
        chk("R1 pwrdn mode", 32'(bus_mode), 32'd0);
        @(negedge clk);
        chk("R1 vpp_err cleared", 32'(vpp_err), 32'd0);
        pin_rst_n = 1'b1;
        @(negedge clk);
        chk("R5 status after clear", 32'(dq_out), 32'h0080);
        idle_pins();

        // Invalid voltage code also refused (R10).
        vpp_lvl = 2'b01; pin_we_n = 1'b0;
        @(negedge clk);
        pin_we_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 invalid no strobe", 32'(cmd_strobe), 32'd0);
        chk("R10 invalid sets err", 32'(vpp_err), 32'd1);
        pin_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        idle_pins(); vpp_lvl = 2'b10;
        @(negedge clk);

        // Write that turns into a conflict never strobes (R8).
        pin_we_n = 1'b0;
        @(negedge clk);
        pin_oe_n = 1'b0;
        @(negedge clk);
        chk("R8 conflict flag", 32'(bus_conflict), 32'd1);
        chk("R8 conflict oe", 32'(dq_oe), 32'h0);
        pin_oe_n = 1'b1; pin_we_n = 1'b1;
        @(negedge clk);
        chk("R8 no strobe a", 32'(cmd_strobe), 32'd0);
        @(negedge clk);
        chk("R8 no strobe b", 32'(cmd_strobe), 32'd0);

        // One-clock sampling latency (R11).
        pin_oe_n = 1'b0;
        #1;
        chk("R11 before edge", 32'(bus_mode), 32'd2);
        @(negedge clk);
        chk("R11 after edge", 32'(bus_mode), 32'd3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule